// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the two USB data line levels and finds a bus reset: both lines held low together for longer than a set time (8 µs by default). The lines are asynchronous to the system clock, so each one first passes through a two-stage synchronizer. A run-length counter then measures how long the synchronized lines stay in the single-ended-zero (SE0) state. When that run passes the threshold, the block emits a one-cycle event. The event sets a sticky status bit and a separate interrupt request bit. The detection is only reported. Nothing in the block resets the processor or any other logic.

The block also has a bus-activity pulse, raised whenever the synchronized line pair changes state. Suspend logic can use it as a wake source. The threshold in clock cycles is computed from the clock rate in kHz and the reset time in µs: T = CLK_KHZ * RESET_US / 1000.

Top module: `usb_busreset_det`

## Requirements
- R1: Each line passes through two synchronizing flops, reset to the idle J state ({dp,dm} = 2'b10). A change driven before clock edge k first shows at the activity output in the cycle after edge k+1.
- R2: Only {dp,dm} = 2'b00 counts as SE0. The J (10), K (01) and SE1 (11) states never advance the run counter, however long they are held.
- R3: The event fires only when SE0 is held for more than T consecutive clock cycles at the inputs. Its single-cycle pulse is visible right after the (T+3)th rising edge that follows the first SE0 sample.
- R4: Each SE0 episode gives at most one event, however long it lasts. Any non-SE0 cycle clears the run counter, so a broken episode starts its count again from zero.
- R5: The status output goes to 1 on the edge after the event and stays there until `stat_clr` is sampled high. When set and clear land in the same cycle, set wins.
- R6: The interrupt output is set by the event and cleared only by `irq_ack`. It is independent of `stat_clr`, and set wins over acknowledge.
- R7: The activity output is high for exactly one cycle for each change of the synchronized line pair. It stays low while the lines are steady.
- R8: After reset, all four outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | D+ line level, asynchronous |
| dm_i | input | 1 | D- line level, asynchronous |
| stat_clr | input | 1 | Clears the sticky bus-reset status bit |
| irq_ack | input | 1 | Acknowledges and clears the interrupt request |
| bus_reset_evt | output | 1 | One-cycle pulse per qualified SE0 episode |
| bus_reset_stat | output | 1 | Sticky bus-reset status |
| bus_reset_irq | output | 1 | Bus-reset interrupt request |
| bus_activity | output | 1 | One-cycle pulse on any synchronized line change |

## Verification
The assertions check, on every cycle:
- the event never lasts two cycles;
- the run counter returns to zero after any non-SE0 sample;
- the counter is saturated whenever the event is raised;
- the status and interrupt bits follow the event on the next edge;
- a clear with no coinciding event drops the status bit.

Only the bench scenarios can show that the event needs more than T held cycles, with its exact latency. They also show that non-SE0 states and broken episodes never fire, and that activity pulses arrive two edges after a line change. The bench sweeps the SE0 hold length across the whole range around the threshold to check these.

// File: rtl/busrst_pkg.sv
package busrst_pkg;

  typedef logic [1:0] line_t;  // {dp, dm}

  localparam line_t LINE_J   = 2'b10;
  localparam line_t LINE_SE0 = 2'b00;

  // Clock cycles in a time window given in microseconds.
  function automatic int unsigned hold_cycles(input int unsigned clk_khz,
                                              input int unsigned win_us);
    return (clk_khz * win_us) / 1000;
  endfunction

  function automatic logic is_se0(input line_t ln);
    return (ln == LINE_SE0);
  endfunction

  // Counter width able to hold 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/se0_timer.sv
module se0_timer #(
  parameter int unsigned THRESH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  output logic fire,
  output logic run_sat
);
  import busrst_pkg::*;

  localparam int unsigned SAT = THRESH + 1;
  localparam int unsigned CW  = cnt_width(SAT);

  logic [CW-1:0] cnt;
  logic          at_thresh;
  logic          at_sat;

  assign at_thresh = (cnt == CW'(THRESH));
  assign at_sat    = (cnt == CW'(SAT));
  assign run_sat   = at_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!se0)   cnt <= '0;
    else if (!at_sat) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire <= 1'b0;
    else        fire <= se0 && at_thresh;
  end

  assert_fire_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !se0 |=> (cnt == '0));
  assert_fire_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> at_sat);
endmodule

// File: rtl/flag_bit.sv
module flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/usb_busreset_det.sv
module usb_busreset_det #(
  parameter int unsigned CLK_KHZ  = 48000,
  parameter int unsigned RESET_US = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_i,
  input  logic dm_i,
  input  logic stat_clr,
  input  logic irq_ack,
  output logic bus_reset_evt,
  output logic bus_reset_stat,
  output logic bus_reset_irq,
  output logic bus_activity
);
  import busrst_pkg::*;

  localparam int unsigned THRESH_RAW = hold_cycles(CLK_KHZ, RESET_US);
  localparam int unsigned THRESH     = (THRESH_RAW < 1) ? 1 : THRESH_RAW;

  line_t line_s;
  line_t line_q;
  logic  se0_s;
  logic  evt;
  logic  run_sat;

  line_sync #(.STAGES(2), .WIDTH(2), .RST_VAL(LINE_J)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dp_i, dm_i}), .q(line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= LINE_J;
    else        line_q <= line_s;
  end

  assign bus_activity = (line_s != line_q);
  assign se0_s        = is_se0(line_s);

  se0_timer #(.THRESH(THRESH)) u_timer (
    .clk(clk), .rst_n(rst_n), .se0(se0_s), .fire(evt), .run_sat(run_sat)
  );

  flag_bit u_stat (.clk(clk), .rst_n(rst_n), .set(evt), .clr(stat_clr), .q(bus_reset_stat));
  flag_bit u_irq  (.clk(clk), .rst_n(rst_n), .set(evt), .clr(irq_ack),  .q(bus_reset_irq));

  assign bus_reset_evt = evt;

  assert_stat_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> bus_reset_stat);
  assert_stat_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !evt) |=> !bus_reset_stat);
  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> bus_reset_irq);
  assert_evt_needs_se0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (run_sat || !se0_s));
endmodule

// File: tb/sim_usb_busreset_det.sv
module sim_usb_busreset_det;
  localparam int unsigned KHZ = 1000;
  localparam int unsigned US  = 8;
  localparam int T = (KHZ * US) / 1000;  // threshold restated: 8 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp_i = 1'b1, dm_i = 1'b0;
  logic stat_clr = 1'b0, irq_ack = 1'b0;
  logic bus_reset_evt, bus_reset_stat, bus_reset_irq, bus_activity;

  int tests = 0, fails = 0;
  int edges = 0;
  int n_evt = 0, n_act = 0, n_stat = 0, evt_edge = -1, act_edge = -1;
  bit done = 1'b0;

  usb_busreset_det #(.CLK_KHZ(KHZ), .RESET_US(US)) u0 (
    .clk(clk), .rst_n(rst_n), .dp_i(dp_i), .dm_i(dm_i),
    .stat_clr(stat_clr), .irq_ack(irq_ack),
    .bus_reset_evt(bus_reset_evt), .bus_reset_stat(bus_reset_stat),
    .bus_reset_irq(bus_reset_irq), .bus_activity(bus_activity)
  );

  always #5 clk = ~clk;
  always @(posedge clk) edges++;

  always @(negedge clk) begin
    if (bus_reset_evt) begin n_evt++; evt_edge = edges; end
    if (bus_activity)  begin n_act++; if (act_edge < 0) act_edge = edges; end
    if (bus_reset_stat) n_stat++;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_evt = 0; n_act = 0; n_stat = 0; evt_edge = -1; act_edge = -1;
  endtask

  task automatic drive(input logic p, input logic m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dp_i = p; dm_i = m;
    end
  endtask

  task automatic acks();
    @(negedge clk); stat_clr = 1'b1; irq_ack = 1'b1;
    @(negedge clk); stat_clr = 1'b0; irq_ack = 1'b0;
  endtask

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    check("R8 evt", bus_reset_evt, 0);
    check("R8 stat", bus_reset_stat, 0);
    check("R8 irq", bus_reset_irq, 0);
    check("R8 act", bus_activity, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clr_counts();
    repeat (5) @(negedge clk);
    check("R7 quiet idle", n_act, 0);

    // R3 R4 R1 sweep of SE0 hold length around the threshold
    for (int n = 0; n <= T + 4; n++) begin
      acks();
      repeat (2) @(negedge clk);
      clr_counts();
      @(negedge clk);
      e0 = edges;
      dp_i = (n == 0); dm_i = 1'b0;
      drive(1'b0, 1'b0, (n > 0) ? n - 1 : 0);
      drive(1'b1, 1'b0, 1);
      repeat (T + 6) @(negedge clk);
      check("R3 event count vs hold", n_evt, (n > T) ? 1 : 0);
      if (n > T) check("R3 event latency", evt_edge, e0 + T + 3);
      check("R7 activity pulses", n_act, (n > 0) ? 2 : 0);
      if (n > 0) check("R1 sync latency", act_edge, e0 + 2);
      check("R5 stat after sweep", bus_reset_stat, (n > T) ? 1 : 0);
      check("R6 irq after sweep", bus_reset_irq, (n > T) ? 1 : 0);
    end

    // R2 non-SE0 states held long
    acks(); clr_counts();
    drive(1'b0, 1'b1, 4 * T);
    drive(1'b1, 1'b1, 4 * T);
    drive(1'b1, 1'b0, 6);
    check("R2 K/SE1 never fire", n_evt, 0);
    check("R7 K/SE1/J changes", n_act, 3);

    // R4 broken episode restarts count
    clr_counts();
    drive(1'b0, 1'b0, T);
    drive(1'b0, 1'b1, 1);
    drive(1'b0, 1'b0, T);
    drive(1'b1, 1'b0, T + 6);
    check("R4 broken episode", n_evt, 0);

    // R4 long episode fires once
    clr_counts();
    drive(1'b0, 1'b0, 5 * T);
    drive(1'b1, 1'b0, 6);
    check("R4 single event long SE0", n_evt, 1);

    // R5 R6 independent clears
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
    check("R5 stat cleared", bus_reset_stat, 0);
    check("R6 irq kept by stat_clr", bus_reset_irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R6 irq acked", bus_reset_irq, 0);

    // R5 R6 set wins over a held clear
    clr_counts();
    stat_clr = 1'b1; irq_ack = 1'b1;
    drive(1'b0, 1'b0, T + 2);
    drive(1'b1, 1'b0, 8);
    check("R5 set wins one cycle", n_stat, 1);
    stat_clr = 1'b0; irq_ack = 1'b0;
    check("R6 irq cleared by held ack", bus_reset_irq, 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule